// File: doc/BRIEF.md
# Windowed Register File with Overlapping Argument Groups

This block is a register file split into a ring of register windows. A 5-bit architectural register number is translated through a current-window pointer to a location in physical storage. Each window reaches four groups of eight registers. The global group is shared by every window. The local group is private to the window. The in group belongs to the window. The out group is the same storage as the in group of the neighbouring window. A caller places arguments in its outs, shifts the window, and the callee finds them in its ins with no copy.

The file has two combinational read ports and one synchronous write port. Two commands move the pointer: a save for a call and a restore for a return. A mask marks windows that may not be entered. A save or restore aimed at a marked window leaves the pointer where it is and raises an overflow or underflow flag. Architectural register 0 always reads as zero.

Top module: `regwin_file`

## Requirements
- R1: After a synchronous reset the window pointer is 0, both flags are low and every register reads zero.
- R2: Architectural numbers 0–7 select the global group, which is the same storage from every window.
- R3: Numbers 16–23 select the window's local group, which no other window can see.
- R4: Numbers 8–15 (outs) of window w address the same storage as numbers 24–31 (ins) of window (w−1) mod 8. This includes the wrap from window 0 to window 7.
- R5: Register 0 always reads zero, and a write to it is discarded.
- R6: A save alone decrements the pointer mod NWIN at the clock edge, and a restore alone increments it. When both or neither are asserted, the pointer holds.
- R7: A save whose target window is marked in the invalid mask leaves the pointer unchanged. It raises overflow_o for the one cycle after that edge. The reset mask marks window 1 only.
- R8: A restore whose target window is marked in the invalid mask leaves the pointer unchanged. It raises underflow_o for the one cycle after that edge.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible after the edge.
- R10: A write issued together with a save or restore is placed using the pointer value from before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs1_addr | input | 5 | Read port 1 architectural register number |
| rs1_data | output | DW | Read port 1 data |
| rs2_addr | input | 5 | Read port 2 architectural register number |
| rs2_data | output | DW | Read port 2 data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural register number |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Shift window for a call (pointer − 1) |
| restore_i | input | 1 | Shift window for a return (pointer + 1) |
| cwp_o | output | log2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Save was refused at the last edge |
| underflow_o | output | 1 | Restore was refused at the last edge |

## Verification
The bench targets the overlap across the wrap from window 0 to window 7. A translation that adds instead of subtracts would hand the callee zeros instead of the caller's arguments. It writes in the same cycle as a save to catch a design that places the data using the new pointer, which would make the value appear in the callee's locals. It drives a chain of saves into the invalid window and a restore into it. A design that moves the pointer anyway, or leaves a flag stuck, shows the wrong pointer or a flag on the following cycle. It also checks register 0 after a write and the old-value read during a write.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;
  localparam int ARCH_W = 5;
  localparam int GRP_SZ = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } grp_e;
endpackage

// File: rtl/regwin_xlate.sv
`timescale 1ns/1ps
// Architectural number to physical index. Physical layout:
// [0..7] globals, then per window w a 16-entry bank: locals then ins.
// NWIN must be a power of two so the pointer wraps by width.
module regwin_xlate #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PAW  = 8
) (
  input  logic [regwin_pkg::ARCH_W-1:0] arch_i,
  input  logic [CW-1:0]                 cwp_i,
  output logic [PAW-1:0]                phys_o
);
  import regwin_pkg::*;
  localparam int BANK = 2 * GRP_SZ;

  grp_e            grp;
  logic [IDX_W-1:0] idx;
  logic [CW-1:0]   prev_w;

  always_comb begin
    grp    = grp_e'(arch_i[ARCH_W-1:IDX_W]);
    idx    = arch_i[IDX_W-1:0];
    prev_w = cwp_i - 1'b1;
    unique case (grp)
      GRP_GLOBAL: phys_o = PAW'(int'(idx));
      GRP_OUT:    phys_o = PAW'(GRP_SZ + int'(prev_w) * BANK + GRP_SZ + int'(idx));
      GRP_LOCAL:  phys_o = PAW'(GRP_SZ + int'(cwp_i) * BANK + int'(idx));
      default:    phys_o = PAW'(GRP_SZ + int'(cwp_i) * BANK + GRP_SZ + int'(idx));
    endcase
  end
endmodule

// File: rtl/regwin_store.sv
`timescale 1ns/1ps
module regwin_store #(
  parameter int DEPTH = 136,
  parameter int PAW   = 8,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we_i,
  input  logic [PAW-1:0] wa_i,
  input  logic [DW-1:0]  wd_i,
  input  logic [PAW-1:0] ra1_i,
  input  logic [PAW-1:0] ra2_i,
  output logic [DW-1:0]  rd1_o,
  output logic [DW-1:0]  rd2_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && (int'(wa_i) < DEPTH)) begin
      mem[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (int'(ra1_i) < DEPTH) ? mem[ra1_i] : '0;
  assign rd2_o = (int'(ra2_i) < DEPTH) ? mem[ra2_i] : '0;
endmodule

// File: rtl/regwin_cwp.sv
`timescale 1ns/1ps
module regwin_cwp #(
  parameter int              NWIN     = 8,
  parameter int              CW       = 3,
  parameter logic [NWIN-1:0] INV_INIT = NWIN'(2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [NWIN-1:0] inv_q;
  logic [CW-1:0]   dn_w, up_w;

  assign dn_w = cwp_o - 1'b1;
  assign up_w = cwp_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      inv_q <= INV_INIT;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (save_i && !restore_i) begin
        if (inv_q[dn_w]) ovf_o <= 1'b1;
        else             cwp_o <= dn_w;
      end else if (restore_i && !save_i) begin
        if (inv_q[up_w]) unf_o <= 1'b1;
        else             cwp_o <= up_w;
      end
    end
  end
endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file #(
  parameter int              NWIN     = 8,
  parameter int              DW       = 32,
  parameter logic [NWIN-1:0] INV_INIT = NWIN'(2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [4:0]               rs1_addr,
  output logic [DW-1:0]            rs1_data,
  input  logic [4:0]               rs2_addr,
  output logic [DW-1:0]            rs2_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     save_i,
  input  logic                     restore_i,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic                     overflow_o,
  output logic                     underflow_o
);
  import regwin_pkg::*;
  localparam int CW    = $clog2(NWIN);
  localparam int DEPTH = GRP_SZ + NWIN * 2 * GRP_SZ;
  localparam int PAW   = $clog2(DEPTH);
  localparam int NPORT = 3;

  logic [ARCH_W-1:0] arch_a [NPORT];
  logic [PAW-1:0]    phys_a [NPORT];
  logic              we_eff;

  assign arch_a[0] = rs1_addr;
  assign arch_a[1] = rs2_addr;
  assign arch_a[2] = wr_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_xl
    regwin_xlate #(.NWIN(NWIN), .CW(CW), .PAW(PAW)) xl_i (
      .arch_i (arch_a[g]),
      .cwp_i  (cwp_o),
      .phys_o (phys_a[g])
    );
  end

  // register 0 is hard zero: its write is dropped here
  assign we_eff = wr_en && (wr_addr != '0);

  regwin_store #(.DEPTH(DEPTH), .PAW(PAW), .DW(DW)) st_i (
    .clk   (clk),
    .rst   (rst),
    .we_i  (we_eff),
    .wa_i  (phys_a[2]),
    .wd_i  (wr_data),
    .ra1_i (phys_a[0]),
    .ra2_i (phys_a[1]),
    .rd1_o (rs1_data),
    .rd2_o (rs2_data)
  );

  regwin_cwp #(.NWIN(NWIN), .CW(CW), .INV_INIT(INV_INIT)) cw_i (
    .clk       (clk),
    .rst       (rst),
    .save_i    (save_i),
    .restore_i (restore_i),
    .cwp_o     (cwp_o),
    .ovf_o     (overflow_o),
    .unf_o     (underflow_o)
  );
endmodule

// File: rtl/regwin_file_chk.sv
`timescale 1ns/1ps
module regwin_file_chk #(
  parameter int              NWIN     = 8,
  parameter int              DW       = 32,
  parameter logic [NWIN-1:0] INV_INIT = NWIN'(2)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4:0]              rs1_addr,
  input logic [DW-1:0]           rs1_data,
  input logic [4:0]              rs2_addr,
  input logic [DW-1:0]           rs2_data,
  input logic                    save_i,
  input logic                    restore_i,
  input logic [$clog2(NWIN)-1:0] cwp_o,
  input logic                    overflow_o,
  input logic                    underflow_o
);
  localparam int CW = $clog2(NWIN);
  logic [CW-1:0] dn, up;
  logic          save_only, rest_only;
  assign dn = cwp_o - 1'b1;
  assign up = cwp_o + 1'b1;
  assign save_only = save_i && !restore_i;
  assign rest_only = restore_i && !save_i;

  assert_save_moves_R6: assert property (@(posedge clk) disable iff (rst)
    save_only && !INV_INIT[dn] |=> cwp_o == $past(dn));
  assert_restore_moves_R6: assert property (@(posedge clk) disable iff (rst)
    rest_only && !INV_INIT[up] |=> cwp_o == $past(up));
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !(save_only || rest_only) |=> $stable(cwp_o));
  assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    save_only && INV_INIT[dn] |=> overflow_o && $stable(cwp_o));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !(save_only && INV_INIT[dn]) |=> !overflow_o);
  assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    rest_only && INV_INIT[up] |=> underflow_o && $stable(cwp_o));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    !(rest_only && INV_INIT[up]) |=> !underflow_o);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> cwp_o == '0 && !overflow_o && !underflow_o);

  always_comb begin
    if (!rst) begin
      assert_zero_rd1_R5: assert (rs1_addr != 5'd0 || rs1_data == '0);
      assert_zero_rd2_R5: assert (rs2_addr != 5'd0 || rs2_data == '0);
    end
  end
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .DW(DW), .INV_INIT(INV_INIT)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rs1_addr    (rs1_addr),
  .rs1_data    (rs1_data),
  .rs2_addr    (rs2_addr),
  .rs2_data    (rs2_data),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .cwp_o       (cwp_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/regwin_file_tb_top.sv
`timescale 1ns/1ps
module regwin_file_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rs1_addr, rs2_addr, wr_addr;
  logic [31:0] rs1_data, rs2_data, wr_data;
  logic        wr_en, save_i, restore_i;
  logic [2:0]  cwp_o;
  logic        overflow_o, underflow_o;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regwin_file dut_i (
    .clk(clk), .rst(rst),
    .rs1_addr(rs1_addr), .rs1_data(rs1_data),
    .rs2_addr(rs2_addr), .rs2_data(rs2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save_i(save_i), .restore_i(restore_i),
    .cwp_o(cwp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {wen, waddr, wdata, save, restore, raddr, exp_data, exp_cwp, exp_ovf, exp_unf}
  localparam int NV = 18;
  localparam logic [81:0] VEC [0:NV-1] = '{
    {1'b1,5'd5 ,32'h11,1'b0,1'b0,5'd5 ,32'h11,3'd0,1'b0,1'b0}, // R2 global write
    {1'b1,5'd0 ,32'hFF,1'b0,1'b0,5'd0 ,32'h00,3'd0,1'b0,1'b0}, // R5 zero reg
    {1'b1,5'd9 ,32'h22,1'b0,1'b0,5'd9 ,32'h22,3'd0,1'b0,1'b0}, // out of w0
    {1'b1,5'd17,32'h33,1'b0,1'b0,5'd17,32'h33,3'd0,1'b0,1'b0}, // local of w0
    {1'b1,5'd25,32'h44,1'b0,1'b0,5'd25,32'h44,3'd0,1'b0,1'b0}, // in of w0
    {1'b0,5'd0 ,32'h00,1'b1,1'b0,5'd25,32'h22,3'd7,1'b0,1'b0}, // R4 wrap overlap
    {1'b0,5'd0 ,32'h00,1'b0,1'b0,5'd17,32'h00,3'd7,1'b0,1'b0}, // R3 private local
    {1'b0,5'd0 ,32'h00,1'b0,1'b0,5'd5 ,32'h11,3'd7,1'b0,1'b0}, // R2 shared global
    {1'b1,5'd17,32'h55,1'b0,1'b0,5'd17,32'h55,3'd7,1'b0,1'b0}, // R3 local of w7
    {1'b0,5'd0 ,32'h00,1'b0,1'b1,5'd17,32'h33,3'd0,1'b0,1'b0}, // R3 w0 local kept
    {1'b0,5'd0 ,32'h00,1'b0,1'b0,5'd25,32'h44,3'd0,1'b0,1'b0}, // in of w0 kept
    {1'b0,5'd0 ,32'h00,1'b0,1'b1,5'd9 ,32'h22,3'd0,1'b0,1'b1}, // R8 restore into w1
    {1'b0,5'd0 ,32'h00,1'b0,1'b0,5'd0 ,32'h00,3'd0,1'b0,1'b0}, // R8 flag drops
    {1'b1,5'd16,32'h66,1'b1,1'b0,5'd16,32'h00,3'd7,1'b0,1'b0}, // R10 write with save
    {1'b0,5'd0 ,32'h00,1'b0,1'b1,5'd16,32'h66,3'd0,1'b0,1'b0}, // R10 lands in w0
    {1'b0,5'd0 ,32'h00,1'b1,1'b1,5'd5 ,32'h11,3'd0,1'b0,1'b0}, // R6 both held
    {1'b0,5'd0 ,32'h00,1'b1,1'b0,5'd9 ,32'h00,3'd7,1'b0,1'b0}, // R4 out w7 = in w6
    {1'b0,5'd0 ,32'h00,1'b0,1'b1,5'd9 ,32'h22,3'd0,1'b0,1'b0}  // R6 back to w0
  };

  task automatic step(input logic [81:0] v);
    wr_en = v[81]; wr_addr = v[80:76]; wr_data = v[75:44];
    save_i = v[43]; restore_i = v[42];
    rs1_addr = v[41:37]; rs2_addr = v[41:37];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; save_i = 1'b0; restore_i = 1'b0;
    #1;
    chk("R9 read port 1", rs1_data, v[36:5]);
    chk("R9 read port 2", rs2_data, v[36:5]);
    chk("R6 window pointer", {29'd0, cwp_o}, {29'd0, v[4:2]});
    chk("R7 overflow flag", {31'd0, overflow_o}, {31'd0, v[1]});
    chk("R8 underflow flag", {31'd0, underflow_o}, {31'd0, v[0]});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; save_i = 0; restore_i = 0;
    rs1_addr = 0; rs2_addr = 0;
    do_reset();
    // R1 reset state
    chk("R1 cwp after reset", {29'd0, cwp_o}, 32'd0);
    chk("R1 flags after reset", {30'd0, overflow_o, underflow_o}, 32'd0);
    for (int a = 0; a < 32; a++) begin
      rs1_addr = 5'(a); #1;
      chk("R1 register cleared", rs1_data, 32'd0);
    end

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R9 same-cycle read returns old value, new one after the edge
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h77; rs1_addr = 5'd5; #1;
    chk("R9 old value during write", rs1_data, 32'h11);
    @(posedge clk); @(negedge clk); wr_en = 1'b0; #1;
    chk("R9 new value after edge", rs1_data, 32'h77);

    // R7 save chain 0->7..2, then save into invalid window 1
    for (int k = 1; k <= 6; k++) begin
      save_i = 1'b1; @(posedge clk); @(negedge clk); save_i = 1'b0; #1;
      chk("R6 save chain pointer", {29'd0, cwp_o}, 32'((8 - k) % 8));
    end
    save_i = 1'b1; @(posedge clk); @(negedge clk); save_i = 1'b0; #1;
    chk("R7 overflow raised", {31'd0, overflow_o}, 32'd1);
    chk("R7 pointer held on overflow", {29'd0, cwp_o}, 32'd2);
    @(posedge clk); @(negedge clk); #1;
    chk("R7 overflow one cycle", {31'd0, overflow_o}, 32'd0);

    // R1 reset clears registers again
    do_reset();
    rs1_addr = 5'd5; rs2_addr = 5'd9; #1;
    chk("R1 global cleared", rs1_data, 32'd0);
    chk("R1 out cleared", rs2_data, 32'd0);
    chk("R1 cwp cleared", {29'd0, cwp_o}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule